// File: doc/BRIEF.md
# Interrupt Destination Bitmask Resolver

This block turns the addressing fields of an interrupt message into the set of interrupt controllers that must receive it. A system holds up to `NUM_SLOTS` controller slots. Each slot has a present flag, an 8-bit physical ID, an 8-bit logical destination and a 4-bit logical model. The slots are loaded one at a time through a configuration write port.

A request gives a destination byte, a mode bit (physical or logical), a 2-bit shorthand code and the index of the sending slot. One cycle later the block returns the full target bitmask. It also returns a one-hot pick of a single target, used for lowest-priority delivery. Fixed, SMI, NMI and INIT deliveries use the full mask. Lowest-priority delivery uses the pick. Message transport and priority arbitration are left to the surrounding logic.

Top module: `ires_dest_resolver`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_valid`, `out_mask` and `out_lowest` are zero. Every slot is marked absent.
- R2: A request sampled with `req_valid` high at a rising edge raises `out_valid` for exactly the following cycle. `out_valid` is low after a cycle without a request.
- R3: With shorthand 0 and `req_logical` = 0, a destination of 8'hFF selects every present slot.
- R4: With shorthand 0, `req_logical` = 0 and any other destination, the mask holds only the lowest-indexed present slot whose physical ID equals the destination. If no present slot has that ID, the mask is empty.
- R5: With shorthand 0 and `req_logical` = 1, a slot whose model is 4'hF (flat) matches when the destination AND its logical destination is nonzero.
- R6: With shorthand 0 and `req_logical` = 1, a slot whose model is 4'h0 (cluster) matches when two conditions hold: the upper nibbles of the destination and the logical destination are equal, and their lower nibbles share a set bit.
- R7: In logical mode, a slot whose model is neither 4'hF nor 4'h0 never matches.
- R8: In logical mode, only slots below the lowest-indexed absent slot can match. Slots above that gap never match.
- R9: Shorthand 1 selects only the sender. Shorthand 2 selects all slots. Shorthand 3 selects all slots except the sender. For a nonzero shorthand, destination and mode have no effect.
- R10: A mask bit for an absent slot is always zero, including the sender's own bit under shorthand 1.
- R11: `out_lowest` is one-hot on the lowest-indexed set bit of `out_mask`. It is zero when the mask is empty.
- R12: `cfg_we` writes the present flag, physical ID, logical destination and model into slot `cfg_slot` at the rising edge. A request in the same cycle still resolves against the earlier contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Slot configuration write strobe |
| cfg_slot | input | IDX_W | Slot index being written |
| cfg_present | input | 1 | Present flag for the slot |
| cfg_phys_id | input | 8 | Physical ID for the slot |
| cfg_log_dest | input | 8 | Logical destination for the slot |
| cfg_model | input | 4 | Logical model: 4'hF flat, 4'h0 cluster |
| req_valid | input | 1 | Request strobe |
| req_dest | input | 8 | Destination byte |
| req_logical | input | 1 | 0 physical, 1 logical |
| req_shorthand | input | 2 | 0 normal, 1 self, 2 all, 3 all but self |
| req_sender | input | IDX_W | Slot index of the sender |
| out_valid | output | 1 | Result valid, one cycle after a request |
| out_mask | output | NUM_SLOTS | Target bitmask, bit i is slot i |
| out_lowest | output | NUM_SLOTS | One-hot lowest-priority target, or zero |

## Verification
The bench builds the block with the default of eight slots. This is enough for several layouts:
- a table with a hole at slot 4 and present slots above it, so the logical scan cut-off shows;
- a duplicate physical ID, so the lowest-index choice in physical lookup shows;
- a mix of flat, cluster and unknown models in one table.

The sender is placed both at slot 0 and at the highest slots, so the self and all-but-self shorthands cover both ends of the mask. A configuration write is also issued in the same cycle as a request on the rewritten slot, to show the ordering between the write and the lookup.

// File: rtl/ires_pkg.sv
package ires_pkg;
  localparam int ID_W    = 8;
  localparam int MODEL_W = 4;
  localparam int NIB_W   = ID_W / 2;

  localparam logic [MODEL_W-1:0] MODEL_FLAT    = {MODEL_W{1'b1}};
  localparam logic [MODEL_W-1:0] MODEL_CLUSTER = {MODEL_W{1'b0}};
  localparam logic [ID_W-1:0]    BCAST_ID      = {ID_W{1'b1}};

  typedef enum logic [1:0] {
    SH_NONE   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  typedef struct packed {
    logic               present;
    logic [ID_W-1:0]    phys_id;
    logic [ID_W-1:0]    log_dest;
    logic [MODEL_W-1:0] model;
  } slot_cfg_t;
endpackage

// File: rtl/ires_slot_table.sv
module ires_slot_table
  import ires_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [IDX_W-1:0]           wr_idx,
  input  slot_cfg_t                  wr_data,
  output slot_cfg_t [NUM_SLOTS-1:0]  cfg_q
);
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[g] <= '0;
      end else if (we && wr_idx == IDX_W'(g)) begin
        cfg_q[g] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/ires_slot_match.sv
module ires_slot_match
  import ires_pkg::*;
(
  input  slot_cfg_t        cfg,
  input  logic [ID_W-1:0]  dest,
  output logic             phys_hit,
  output logic             log_hit
);
  always_comb begin
    phys_hit = cfg.present && (cfg.phys_id == dest);
    log_hit  = 1'b0;
    if (cfg.present) begin
      if (cfg.model == MODEL_FLAT) begin
        log_hit = |(dest & cfg.log_dest);
      end else if (cfg.model == MODEL_CLUSTER) begin
        log_hit = (dest[ID_W-1:NIB_W] == cfg.log_dest[ID_W-1:NIB_W]) &&
                  (|(dest[NIB_W-1:0] & cfg.log_dest[NIB_W-1:0]));
      end
    end
  end
endmodule

// File: rtl/ires_lowest_pick.sv
module ires_lowest_pick #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] req,
  output logic [WIDTH-1:0] grant
);
  always_comb grant = req & (~req + WIDTH'(1));
endmodule

// File: rtl/ires_dest_resolver.sv
module ires_dest_resolver
  import ires_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [IDX_W-1:0]      cfg_slot,
  input  logic                  cfg_present,
  input  logic [ID_W-1:0]       cfg_phys_id,
  input  logic [ID_W-1:0]       cfg_log_dest,
  input  logic [MODEL_W-1:0]    cfg_model,
  input  logic                  req_valid,
  input  logic [ID_W-1:0]       req_dest,
  input  logic                  req_logical,
  input  logic [1:0]            req_shorthand,
  input  logic [IDX_W-1:0]      req_sender,
  output logic                  out_valid,
  output logic [NUM_SLOTS-1:0]  out_mask,
  output logic [NUM_SLOTS-1:0]  out_lowest
);
  slot_cfg_t [NUM_SLOTS-1:0] cfg_q;
  slot_cfg_t                 wr_data;
  logic [NUM_SLOTS-1:0]      present_vec;
  logic [NUM_SLOTS-1:0]      phys_hit;
  logic [NUM_SLOTS-1:0]      log_hit;
  logic [NUM_SLOTS-1:0]      scan_ok;
  logic [NUM_SLOTS-1:0]      phys_first;
  logic [NUM_SLOTS-1:0]      self_oh;
  logic [NUM_SLOTS-1:0]      normal_mask;
  logic [NUM_SLOTS-1:0]      mask_next;
  logic [NUM_SLOTS-1:0]      lowest_next;
  shorthand_e                sh;

  assign wr_data = '{present: cfg_present, phys_id: cfg_phys_id,
                     log_dest: cfg_log_dest, model: cfg_model};

  ires_slot_table #(.NUM_SLOTS(NUM_SLOTS)) u_table (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .wr_idx (cfg_slot),
    .wr_data(wr_data),
    .cfg_q  (cfg_q)
  );

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_match
    assign present_vec[g] = cfg_q[g].present;
    ires_slot_match u_match (
      .cfg     (cfg_q[g]),
      .dest    (req_dest),
      .phys_hit(phys_hit[g]),
      .log_hit (log_hit[g])
    );
    // logical scan only reaches slots below the first gap
    if (g == 0) begin : g_head
      assign scan_ok[g] = present_vec[g];
    end else begin : g_chain
      assign scan_ok[g] = present_vec[g] & scan_ok[g-1];
    end
  end

  ires_lowest_pick #(.WIDTH(NUM_SLOTS)) u_phys_pick (
    .req  (phys_hit),
    .grant(phys_first)
  );

  always_comb begin
    sh      = shorthand_e'(req_shorthand);
    self_oh = {{(NUM_SLOTS-1){1'b0}}, 1'b1} << req_sender;
    if (req_logical) begin
      normal_mask = log_hit & scan_ok;
    end else if (req_dest == BCAST_ID) begin
      normal_mask = present_vec;
    end else begin
      normal_mask = phys_first;
    end
    case (sh)
      SH_SELF:   mask_next = self_oh & present_vec;
      SH_ALL:    mask_next = present_vec;
      SH_OTHERS: mask_next = present_vec & ~self_oh;
      default:   mask_next = normal_mask;
    endcase
  end

  ires_lowest_pick #(.WIDTH(NUM_SLOTS)) u_lp_pick (
    .req  (mask_next),
    .grant(lowest_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_mask   <= '0;
      out_lowest <= '0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_mask   <= mask_next;
        out_lowest <= lowest_next;
      end
    end
  end
endmodule

// File: rtl/ires_dest_resolver_chk.sv
module ires_dest_resolver_chk #(
  parameter int NUM_SLOTS = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_valid,
  input logic [1:0]           req_shorthand,
  input logic [NUM_SLOTS-1:0] present,
  input logic                 out_valid,
  input logic [NUM_SLOTS-1:0] out_mask,
  input logic [NUM_SLOTS-1:0] out_lowest
);
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid);
  p_lowest_onehot_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(out_lowest));
  p_lowest_in_mask_r11: assert property (@(posedge clk) disable iff (rst)
    (out_lowest & ~out_mask) == '0);
  p_lowest_nonempty_r11: assert property (@(posedge clk) disable iff (rst)
    (out_mask != '0) |-> (out_lowest != '0));
  p_absent_zero_r10: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (out_mask & ~$past(present)) == '0);
  p_all_shorthand_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_shorthand == 2'd2) |=> out_mask == $past(present));
endmodule

bind ires_dest_resolver ires_dest_resolver_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_shorthand(req_shorthand),
  .present      (present_vec),
  .out_valid    (out_valid),
  .out_mask     (out_mask),
  .out_lowest   (out_lowest)
);

// File: tb/ires_dest_resolver_bench.sv
module ires_dest_resolver_bench;
  localparam int NS = 8;
  localparam int IW = $clog2(NS);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_slot = '0;
  logic          cfg_present = 1'b0;
  logic [7:0]    cfg_phys_id = '0;
  logic [7:0]    cfg_log_dest = '0;
  logic [3:0]    cfg_model = '0;
  logic          req_valid = 1'b0;
  logic [7:0]    req_dest = '0;
  logic          req_logical = 1'b0;
  logic [1:0]    req_shorthand = '0;
  logic [IW-1:0] req_sender = '0;
  logic          out_valid;
  logic [NS-1:0] out_mask;
  logic [NS-1:0] out_lowest;

  always #10 clk = ~clk;

  ires_dest_resolver #(.NUM_SLOTS(NS)) u_ires_dest_resolver (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_present(cfg_present),
    .cfg_phys_id(cfg_phys_id), .cfg_log_dest(cfg_log_dest), .cfg_model(cfg_model),
    .req_valid(req_valid), .req_dest(req_dest), .req_logical(req_logical),
    .req_shorthand(req_shorthand), .req_sender(req_sender),
    .out_valid(out_valid), .out_mask(out_mask), .out_lowest(out_lowest)
  );

  int checks = 0;
  int errors = 0;
  bit cmp_en = 1'b0;
  string cur_tag = "R2";

  // reference model state
  bit       m_pres [NS];
  bit [7:0] m_id   [NS];
  bit [7:0] m_ld   [NS];
  bit [3:0] m_mod  [NS];
  bit          e_valid;
  bit [NS-1:0] e_mask;
  bit [NS-1:0] e_low;
  string       e_tag;

  task automatic check(string tag, logic [NS-1:0] got, logic [NS-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b expected=%b at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic bit [NS-1:0] model_mask(bit [7:0] d, bit lg, bit [1:0] s, int snd);
    bit [NS-1:0] m = '0;
    bit found = 0;
    if (s == 2'd1) begin
      if (m_pres[snd]) m[snd] = 1'b1;
    end else if (s == 2'd2 || s == 2'd3) begin
      for (int i = 0; i < NS; i++) if (m_pres[i]) m[i] = 1'b1;
      if (s == 2'd3) m[snd] = 1'b0;
    end else if (!lg) begin
      for (int i = 0; i < NS; i++) begin
        if (d == 8'hFF) begin
          if (m_pres[i]) m[i] = 1'b1;
        end else if (!found && m_pres[i] && m_id[i] == d) begin
          m[i] = 1'b1;
          found = 1;
        end
      end
    end else begin
      for (int i = 0; i < NS; i++) begin
        if (!m_pres[i]) break;
        if (m_mod[i] == 4'hF && (d & m_ld[i]) != 0) m[i] = 1'b1;
        if (m_mod[i] == 4'h0 && d[7:4] == m_ld[i][7:4] && (d[3:0] & m_ld[i][3:0]) != 0)
          m[i] = 1'b1;
      end
    end
    return m;
  endfunction

  function automatic bit [NS-1:0] model_low(bit [NS-1:0] m);
    for (int i = 0; i < NS; i++) if (m[i]) return NS'(1) << i;
    return '0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      e_valid = 0; e_mask = '0; e_low = '0;
      for (int i = 0; i < NS; i++) begin
        m_pres[i] = 0; m_id[i] = 0; m_ld[i] = 0; m_mod[i] = 0;
      end
    end else begin
      e_valid = req_valid;
      if (req_valid) begin
        e_mask = model_mask(req_dest, req_logical, req_shorthand, int'(req_sender));
        e_low  = model_low(e_mask);
        e_tag  = cur_tag;
      end
      if (cfg_we) begin
        m_pres[cfg_slot] = cfg_present;
        m_id[cfg_slot]   = cfg_phys_id;
        m_ld[cfg_slot]   = cfg_log_dest;
        m_mod[cfg_slot]  = cfg_model;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      check("R2", NS'(out_valid), NS'(e_valid));
      if (e_valid) begin
        check(e_tag, out_mask, e_mask);
        check("R11", out_lowest, e_low);
      end
    end
  end

  task automatic wr(int slot, bit p, bit [7:0] id, bit [7:0] ld, bit [3:0] md);
    @(negedge clk);
    cfg_we = 1; cfg_slot = IW'(slot); cfg_present = p;
    cfg_phys_id = id; cfg_log_dest = ld; cfg_model = md;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rq(string tag, bit [7:0] d, bit lg, bit [1:0] s, int snd);
    @(negedge clk);
    cur_tag = tag;
    req_valid = 1; req_dest = d; req_logical = lg;
    req_shorthand = s; req_sender = IW'(snd);
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1", {out_lowest[NS-2:0], out_valid}, '0);
    check("R1", out_mask, '0);
    rst = 0;
    cmp_en = 1;
    // R1: no slot present right after reset
    rq("R1", 8'hFF, 0, 2'd0, 0);
    wr(0, 1, 8'h10, 8'h01, 4'hF);
    wr(1, 1, 8'h11, 8'h02, 4'hF);
    wr(2, 1, 8'h22, 8'h0C, 4'hF);
    wr(3, 1, 8'h11, 8'h80, 4'hF);
    wr(5, 1, 8'h05, 8'hFF, 4'hF);
    wr(7, 1, 8'h07, 8'h21, 4'h0);
    rq("R4", 8'h11, 0, 2'd0, 0);
    rq("R4", 8'h05, 0, 2'd0, 0);
    rq("R4", 8'h99, 0, 2'd0, 0);
    rq("R3", 8'hFF, 0, 2'd0, 0);
    rq("R5", 8'h03, 1, 2'd0, 0);
    rq("R5", 8'h80, 1, 2'd0, 0);
    rq("R8", 8'hFF, 1, 2'd0, 0);
    rq("R8", 8'h21, 1, 2'd0, 0);
    wr(4, 1, 8'h04, 8'h23, 4'h0);
    wr(6, 1, 8'h06, 8'h31, 4'h5);
    rq("R6", 8'h21, 1, 2'd0, 0);
    rq("R6", 8'h22, 1, 2'd0, 0);
    rq("R7", 8'h31, 1, 2'd0, 0);
    rq("R9", 8'h10, 0, 2'd1, 2);
    rq("R9", 8'h10, 0, 2'd3, 0);
    rq("R9", 8'h99, 1, 2'd2, 7);
    rq("R9", 8'hFF, 0, 2'd3, 7);
    wr(5, 0, 8'h05, 8'hFF, 4'hF);
    rq("R10", 8'h05, 0, 2'd1, 5);
    rq("R10", 8'h00, 0, 2'd2, 0);
    rq("R10", 8'h00, 0, 2'd3, 7);
    // R12: write and request in the same cycle
    @(negedge clk);
    cfg_we = 1; cfg_slot = IW'(1); cfg_present = 1;
    cfg_phys_id = 8'h55; cfg_log_dest = 8'h40; cfg_model = 4'hF;
    cur_tag = "R12"; req_valid = 1; req_dest = 8'h55; req_logical = 0;
    req_shorthand = 2'd0; req_sender = '0;
    @(negedge clk);
    cfg_we = 0; req_valid = 0;
    rq("R12", 8'h55, 0, 2'd0, 0);
    rq("R12", 8'h40, 1, 2'd0, 0);
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule